// File: doc/BRIEF.md
# Ethernet receive preamble synchronizer

This block sits after the line decoder of an Ethernet receiver. It takes carrier sense, a recovered data bit and a strobe that marks each valid bit. It strips the preamble, finds the two-ones end-of-preamble marker, and then packs the frame bits that follow into bytes. When carrier sense rises, the block first ignores a fixed window of bit times so that the decoder's clock recovery can settle. Only then does it look at bit pairs. If a pair of ones arrives first, it raises a one-cycle start-of-frame pulse, and every following group of eight bits comes out as a byte with a strobe. If a pair of zeros arrives first, the preamble is corrupt. The block then raises a one-cycle error pulse and stays silent until carrier drops and returns.

The control is a five-state machine. The states are IDLE (no carrier), BLANK (lock-in window), HUNT (pair search), DATA (byte packing) and ABORT (corrupt preamble, waiting for carrier loss). The transitions are:

- IDLE→BLANK when carrier is high.
- BLANK→HUNT on the last strobe of the window.
- HUNT→DATA on a ones pair.
- HUNT→ABORT on a zeros pair.
- Any state other than IDLE →IDLE when carrier is low.

All three pulses and the byte bus are registered. Each appears in the clock cycle after the strobe that causes it.

Top module: `rx_preamble_sync`

## Requirements
- R1: After reset all pulse outputs are low, the byte bus is zero and the machine is in IDLE.
- R2: The first BLANK_BITS (default 16) bit strobes after carrier rises are ignored. No ones pair or zeros pair inside this window produces any output.
- R3: After the window, the first two consecutive ones cause a start-of-frame pulse one clock wide. The pulse appears in the cycle after the strobe of the second one.
- R4: Two consecutive zeros after the window and before any ones pair cause a one-cycle error pulse. After that, no start-of-frame pulse and no byte strobe appear until carrier has gone low and risen again.
- R5: The bits after the marker are packed least significant bit first. The first bit after the marker lands in bit 0. A byte strobe appears once for every eighth bit, and the byte bus holds the byte in that same cycle.
- R6: Carrier low in any state returns the machine to IDLE. A partially collected byte is discarded. A strobe in the same cycle as carrier low has no effect.
- R7: Pair history starts empty when the search begins. The last window bit never forms a pair with the first search bit.
- R8: Start-of-frame, byte strobe and error pulse are never high in the same cycle.
- R9: Cycles without a bit strobe change nothing, whatever the value on the bit input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_i | input | 1 | Carrier sense, high while the line is active |
| bit_i | input | 1 | Recovered data bit |
| bit_stb_i | input | 1 | High for one cycle when bit_i holds a new bit |
| sof_o | output | 1 | One-cycle start-of-frame pulse |
| byte_o | output | 8 | Last completed frame byte |
| byte_vld_o | output | 1 | One-cycle strobe, byte_o is new |
| err_o | output | 1 | One-cycle corrupt-preamble pulse |

## Verification
Two events can meet in one cycle. Carrier loss can coincide with the strobe that would finish a byte, or with the strobe that would complete the ones marker. The bench drives carrier low and the strobe at the same clock edge. The scoreboard expects no byte strobe and no start-of-frame from that edge. Any such event that does appear is an unexpected item and is reported as a failure. A following clean frame confirms that the machine returned to IDLE and starts a fresh window.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BLANK = 3'd1,
        ST_HUNT  = 3'd2,
        ST_DATA  = 3'd3,
        ST_ABORT = 3'd4
    } rxps_state_e;

endpackage

// File: rtl/rxps_blank_cnt.sv
module rxps_blank_cnt #(
    parameter int BLANK_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic done
);
    localparam int CW = (BLANK_BITS > 1) ? $clog2(BLANK_BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLANK_BITS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign done = step && (cnt_q == LAST);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !done);

endmodule

// File: rtl/rxps_pair_det.sv
module rxps_pair_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic bit_i,
    output logic pair_ones,
    output logic pair_zeros
);
    logic prev_q;
    logic prev_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_q     <= 1'b0;
            prev_vld_q <= 1'b0;
        end else if (step) begin
            prev_q     <= bit_i;
            prev_vld_q <= 1'b1;
        end
    end

    assign pair_ones  = step && prev_vld_q && prev_q && bit_i;
    assign pair_zeros = step && prev_vld_q && !prev_q && !bit_i;

    // R7
    fresh_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !(pair_ones || pair_zeros));

endmodule

// File: rtl/rxps_byte_pack.sv
module rxps_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              bit_i,
    output logic              full,
    output logic [BYTE_W-1:0] word
);
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [CW-1:0]     cnt_q;
    logic [BYTE_W-1:0] sh_q;

    assign word = {bit_i, sh_q[BYTE_W-1:1]};
    assign full = step && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            sh_q  <= word;
        end
    end

    // R5
    pack_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !full);

endmodule

// File: rtl/rx_preamble_sync.sv
module rx_preamble_sync #(
    parameter int BLANK_BITS = 16,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_i,
    input  logic              bit_i,
    input  logic              bit_stb_i,
    output logic              sof_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              err_o
);
    import rxps_pkg::*;

    rxps_state_e state_q, state_d;

    logic live_stb;
    logic blank_done;
    logic pair_ones, pair_zeros;
    logic byte_full;
    logic [BYTE_W-1:0] byte_word;

    assign live_stb = bit_stb_i && carrier_i;

    rxps_blank_cnt #(.BLANK_BITS(BLANK_BITS)) blank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_BLANK),
        .step  (live_stb && (state_q == ST_BLANK)),
        .done  (blank_done)
    );

    rxps_pair_det pair_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (state_q != ST_HUNT),
        .step       (live_stb && (state_q == ST_HUNT)),
        .bit_i      (bit_i),
        .pair_ones  (pair_ones),
        .pair_zeros (pair_zeros)
    );

    rxps_byte_pack #(.BYTE_W(BYTE_W)) pack_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_DATA),
        .step  (live_stb && (state_q == ST_DATA)),
        .bit_i (bit_i),
        .full  (byte_full),
        .word  (byte_word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (carrier_i) state_d = ST_BLANK;
            ST_BLANK: begin
                if (!carrier_i)      state_d = ST_IDLE;
                else if (blank_done) state_d = ST_HUNT;
            end
            ST_HUNT: begin
                if (!carrier_i)      state_d = ST_IDLE;
                else if (pair_ones)  state_d = ST_DATA;
                else if (pair_zeros) state_d = ST_ABORT;
            end
            ST_DATA:  if (!carrier_i) state_d = ST_IDLE;
            ST_ABORT: if (!carrier_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_o      <= 1'b0;
            err_o      <= 1'b0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            sof_o      <= (state_q == ST_HUNT) && pair_ones;
            err_o      <= (state_q == ST_HUNT) && pair_zeros;
            byte_vld_o <= (state_q == ST_DATA) && byte_full;
            if ((state_q == ST_DATA) && byte_full) byte_o <= byte_word;
        end
    end

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sof_o, byte_vld_o, err_o}));

    // R6
    carrier_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_i |=> !sof_o && !byte_vld_o && !err_o);

    // R9
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb_i |=> !sof_o && !byte_vld_o && !err_o);

    // R2
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |=> !sof_o && !err_o && !byte_vld_o);

    // R3
    sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |=> !sof_o && (state_q != ST_HUNT));

    // R4
    abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT) |=> !sof_o && !byte_vld_o);

    // R5
    byte_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $past(state_q == ST_DATA));

endmodule

// File: tb/rx_preamble_sync_tb_top.sv
module rx_preamble_sync_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       bit_stb_i = 1'b0;
    logic       sof_o, byte_vld_o, err_o;
    logic [7:0] byte_o;

    always #2 clk = ~clk;

    rx_preamble_sync dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_i  (carrier_i),
        .bit_i      (bit_i),
        .bit_stb_i  (bit_stb_i),
        .sof_o      (sof_o),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o),
        .err_o      (err_o)
    );

    typedef struct {
        int         kind;   // 0 sof, 1 byte, 2 error
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ev(input int kind, input logic [7:0] data, input string tag);
        exp_t e;
        e.kind = kind; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send_bit(input logic b);
        bit_i = b; bit_stb_i = 1'b1;
        tick(1);
        bit_stb_i = 1'b0;
        tick(2);
    endtask

    task automatic send_alt(input int n, input logic first);
        for (int i = 0; i < n; i++) send_bit(first ^ i[0]);
    endtask

    task automatic carrier_on();
        carrier_i = 1'b1;
        tick(2);
    endtask

    task automatic carrier_off();
        carrier_i = 1'b0;
        tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        for (int i = 0; i < 8; i++) begin
            if (i == 7) expect_ev(1, b, tag);
            send_bit(b[i]);
        end
    endtask

    task automatic good_preamble(input string tag);
        carrier_on();
        send_alt(62, 1'b1);
        send_bit(1'b1);
        expect_ev(0, 8'h00, tag);
        send_bit(1'b1);
    endtask

    task automatic settle(input string tag);
        tick(6);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: pending expected events actual %0d expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && (sof_o || byte_vld_o || err_o)) begin
            int kind;
            exp_t e;
            kind = sof_o ? 0 : (byte_vld_o ? 1 : 2);
            checks++;
            if ((32'(sof_o) + 32'(byte_vld_o) + 32'(err_o)) > 1) begin
                errors++;
                $display("FAIL R8: pulses sof=%0b vld=%0b err=%0b expected at most one", sof_o, byte_vld_o, err_o);
            end else if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected event: actual kind %0d data %02h expected none", kind, byte_o);
            end else begin
                e = exp_q.pop_front();
                if (e.kind != kind || (kind == 1 && e.data != byte_o)) begin
                    errors++;
                    $display("FAIL %s: actual kind %0d data %02h expected kind %0d data %02h",
                             e.tag, kind, byte_o, e.kind, e.data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1: reset state
        checks++;
        if (sof_o !== 1'b0 || byte_vld_o !== 1'b0 || err_o !== 1'b0 || byte_o !== 8'h00) begin
            errors++;
            $display("FAIL R1: outputs %b%b%b %02h expected 000 00", sof_o, byte_vld_o, err_o, byte_o);
        end
        rst_n = 1'b1;
        tick(2);

        // R3 R5: normal frame, LSB first packing
        good_preamble("R3");
        send_byte(8'hA5, "R5");
        send_byte(8'h3C, "R5");
        send_byte(8'hFF, "R5");
        carrier_off();
        settle("R5");

        // R2: pairs inside the blank window ignored
        carrier_on();
        for (int i = 0; i < 4; i++) begin
            send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        end
        send_alt(6, 1'b1);
        send_bit(1'b1);
        expect_ev(0, 8'h00, "R2");
        send_bit(1'b1);
        send_byte(8'h81, "R2");
        carrier_off();
        settle("R2");

        // R4: zeros pair aborts until carrier returns
        carrier_on();
        send_alt(16, 1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        expect_ev(2, 8'h00, "R4");
        send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1);
        send_alt(16, 1'b0);
        carrier_off();
        settle("R4");
        good_preamble("R4");
        send_byte(8'h5A, "R4");
        carrier_off();
        settle("R4");

        // R7: last blank bit and first hunt bit do not pair; R9: no strobe, no effect
        carrier_on();
        send_alt(16, 1'b0);          // window ends with a one
        send_bit(1'b1);              // first search bit, must not pair
        bit_i = 1'b1; tick(5);       // R9: wiggle bit without strobe
        bit_i = 1'b0; tick(3);
        bit_i = 1'b1; tick(3);
        send_bit(1'b0);
        send_bit(1'b1);
        expect_ev(0, 8'h00, "R7");
        send_bit(1'b1);
        bit_i = 1'b0; tick(4); bit_i = 1'b1; tick(4);   // R9 inside data
        send_byte(8'h96, "R9");
        carrier_off();
        settle("R7");

        // R6: partial byte discarded on carrier loss
        good_preamble("R6");
        send_alt(5, 1'b1);
        carrier_off();
        settle("R6");

        // R6: carrier drop in same cycle as eighth strobe
        good_preamble("R6");
        send_alt(7, 1'b1);
        bit_i = 1'b1; bit_stb_i = 1'b1; carrier_i = 1'b0;
        tick(1);
        bit_stb_i = 1'b0;
        tick(3);
        settle("R6");

        // R6: carrier drop with the marker's second one
        carrier_on();
        send_alt(20, 1'b1);
        send_bit(1'b1);
        bit_i = 1'b1; bit_stb_i = 1'b1; carrier_i = 1'b0;
        tick(1);
        bit_stb_i = 1'b0;
        tick(3);
        settle("R6");

        // R6 R2: carrier drop inside window, then a fresh window
        carrier_on();
        send_alt(10, 1'b1);
        carrier_off();
        good_preamble("R6");
        send_byte(8'h00, "R6");
        send_byte(8'h7E, "R6");
        carrier_off();
        settle("R6");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule